// File: doc/BRIEF.md
# Multichannel Phase-Delayed CW Square-Wave Generator

The block drives an array of square-wave continuous-wave (CW) transmit outputs from one shared clock. All channels share one programmable divider that sets the half-period. Each channel also has its own programmable start delay, counted in clock cycles, so the array of outputs can be steered and focused. Each output is a driven level paired with an output-enable. When the output-enable is low, the pin is treated as high impedance.

Software loads the settings through a simple parallel write port: one delay per channel, the shared divider and a per-channel high-impedance mask. Transmission is gated by two inputs. `enable` must be high, and a rising `tx_run` then starts every channel from one common edge. Settings are captured at that edge. A write made while the array is transmitting therefore changes nothing until the next start. Dropping `tx_run` or `enable` returns every output to high impedance and clears all counters. The next start then reproduces exactly the same phase relationship.

Top module: `cw_beam_gen`

## Requirements
- R1: A synchronous active-low reset clears the divider, every channel delay and the mask to 0, and drives every `cw_oe` and `cw_level` bit to 0.
- R2: While a channel is toggling, each high and each low half-period lasts divider+1 clock cycles. A divider of 0 therefore toggles the output on every clock.
- R3: Let a start edge be edge 0. A channel with delay D and divider N then shows level 0 through edge D+N, and level 1 first after edge D+N+1. Delays from 0 to 255 are honoured.
- R4: When `tx_run` is sampled low, all `cw_oe` and `cw_level` bits are 0 after that edge.
- R5: A channel whose captured mask bit is 1 has `cw_oe` and `cw_level` at 0 for the whole run. Unmasked channels have `cw_oe` at 1 from the edge after the start.
- R6: When `enable` is sampled low, all outputs are 0 after that edge. A start requires `enable` and `tx_run` to be high together.
- R7: The write port maps addresses 0 to 7 to the channel delays (address = channel index), address 8 to the divider and address 9 to the mask (data bit i = channel i). Writes to addresses 10 to 15 change nothing.
- R8: Settings are captured at the start edge, using the register values from before that edge. A write during a run, or a write on the start edge itself, affects only the next start.
- R9: Stopping a run clears every counter. A restart with unchanged settings reproduces the same waveform, cycle for cycle, relative to its start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all channels |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low idles all channels |
| tx_run | input | 1 | Transmit gate; a rising level starts all channels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cw_level | output | 8 | Driven level per channel, 0 when not enabled |
| cw_oe | output | 8 | Output-enable per channel; 0 means high impedance |

## Verification
The hardest case to produce from the ports is a start edge that coincides with a register write, together with writes landing mid-run. In either case the live register and the captured copy must disagree for the rest of the run. The stimulus drives a write on the same falling edge that raises `tx_run`, and it also rewrites the divider, delays and mask in the middle of long runs. The reference model captures its settings before applying the write of the same cycle, and the outputs are compared with it on every clock. Long delays near 255 and a divider of 0 are exercised separately, to cover the boundaries of the count.

// File: rtl/cwb_pkg.sv
// Shared definitions for the CW beam generator.
// Assumes the channel count does not exceed the register data width.
package cwb_pkg;
    // Register address of the shared divider, placed after the delay slots.
    function automatic int div_addr(input int num_ch);
        return num_ch;
    endfunction
    // Register address of the high-impedance mask.
    function automatic int mask_addr(input int num_ch);
        return num_ch + 1;
    endfunction
endpackage

// File: rtl/cwb_run_ctrl.sv
// Run gate: combines enable and tx_run into a start pulse and a hold level.
// Assumes both inputs are synchronous to clk.
module cwb_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tx_run,
    output logic start_o,
    output logic hold_o
);
    logic active;
    logic run_q;

    assign active  = enable & tx_run;
    assign start_o = active & ~run_q;
    assign hold_o  = active & run_q;

    // Remember whether the array was transmitting in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= active;
    end

    a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (enable && tx_run));
    a_r4_hold_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_run |=> !run_q);
endmodule

// File: rtl/cwb_cfg_regs.sv
// Configuration registers with a run-time capture copy.
// The live copy takes writes at any time. The captured divider and mask
// follow the live copy only on a start pulse, using pre-edge values.
module cwb_cfg_regs #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [CNT_W-1:0]             wdata,
    input  logic                         start_i,
    output logic [NUM_CH-1:0][CNT_W-1:0] dly_o,
    output logic [CNT_W-1:0]             div_snap_o,
    output logic [NUM_CH-1:0]            mask_o,
    output logic [NUM_CH-1:0]            mask_snap_o
);
    import cwb_pkg::*;
    localparam int DIV_A  = div_addr(NUM_CH);
    localparam int MASK_A = mask_addr(NUM_CH);

    logic [CNT_W-1:0] div_q;

    // Live register file: one delay per channel, divider and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_o  <= '0;
            div_q  <= '0;
            mask_o <= '0;
        end else if (we) begin
            for (int c = 0; c < NUM_CH; c++)
                if (addr == ADDR_W'(c)) dly_o[c] <= wdata;
            if (addr == ADDR_W'(DIV_A))  div_q  <= wdata;
            if (addr == ADDR_W'(MASK_A)) mask_o <= wdata[NUM_CH-1:0];
        end
    end

    // Capture copy used for the duration of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_snap_o  <= '0;
            mask_snap_o <= '0;
        end else if (start_i) begin
            div_snap_o  <= div_q;
            mask_snap_o <= mask_o;
        end
    end

    a_r8_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(div_snap_o) && $stable(mask_snap_o));
endmodule

// File: rtl/cwb_channel.sv
// One CW channel: start delay countdown, then a half-period counter that
// toggles the level every div_i+1 cycles. All state clears when no run.
module cwb_channel #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] dly_i,
    input  logic [CNT_W-1:0] div_i,
    input  logic             hide_start_i,
    input  logic             hide_run_i,
    output logic             level_o,
    output logic             oe_o
);
    logic             wait_q;
    logic [CNT_W-1:0] dly_q;
    logic [CNT_W-1:0] half_q;
    logic             lvl_q;
    logic             oe_q;

    // Delay countdown and half-period counter with output toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || (!start_i && !hold_i)) begin
            wait_q <= 1'b0;
            dly_q  <= '0;
            half_q <= '0;
            lvl_q  <= 1'b0;
        end else if (start_i) begin
            wait_q <= (dly_i != '0);
            dly_q  <= dly_i;
            half_q <= '0;
            lvl_q  <= 1'b0;
        end else if (wait_q) begin
            dly_q <= dly_q - 1'b1;
            if (dly_q == CNT_W'(1)) wait_q <= 1'b0;
        end else if (half_q == div_i) begin
            half_q <= '0;
            lvl_q  <= ~lvl_q;
        end else begin
            half_q <= half_q + 1'b1;
        end
    end

    // Output-enable: mask at start from the live bit, then the captured bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_q <= 1'b0;
        else if (start_i) oe_q <= ~hide_start_i;
        else if (hold_i)  oe_q <= ~hide_run_i;
        else              oe_q <= 1'b0;
    end

    assign level_o = lvl_q & oe_q;
    assign oe_o    = oe_q;

    a_r3_quiet_in_delay: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q |-> !lvl_q);
    a_r2_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !wait_q) |-> half_q <= div_i);
    a_r2_no_early_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !wait_q && half_q != div_i) |=> (lvl_q == $past(lvl_q)) || !oe_q && !lvl_q);
    a_r5_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && hide_run_i) |=> !oe_o && !level_o);
endmodule

// File: rtl/cw_beam_gen.sv
// Top: multichannel phase-delayed CW square-wave generator.
// Assumes NUM_CH <= CNT_W so the mask fits in one register write.
module cw_beam_gen #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_run,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    output logic [NUM_CH-1:0] cw_level,
    output logic [NUM_CH-1:0] cw_oe
);
    logic                         start;
    logic                         hold;
    logic [NUM_CH-1:0][CNT_W-1:0] dly;
    logic [CNT_W-1:0]             div_snap;
    logic [NUM_CH-1:0]            mask_live;
    logic [NUM_CH-1:0]            mask_snap;

    cwb_run_ctrl i_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tx_run  (tx_run),
        .start_o (start),
        .hold_o  (hold)
    );

    cwb_cfg_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .start_i     (start),
        .dly_o       (dly),
        .div_snap_o  (div_snap),
        .mask_o      (mask_live),
        .mask_snap_o (mask_snap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cwb_channel #(.CNT_W(CNT_W)) i_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .start_i      (start),
            .hold_i       (hold),
            .dly_i        (dly[c]),
            .div_i        (div_snap),
            .hide_start_i (mask_live[c]),
            .hide_run_i   (mask_snap[c]),
            .level_o      (cw_level[c]),
            .oe_o         (cw_oe[c])
        );
    end

    a_r4_hiz_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_run |=> (cw_oe == '0) && (cw_level == '0));
    a_r6_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cw_oe == '0) && (cw_level == '0));
    a_r5_level_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_level & ~cw_oe) == '0);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (cw_oe == '0));
endmodule

// File: tb/test_cw_beam_gen.sv
// Bench: behavioural reference model compared with the outputs every clock.
module test_cw_beam_gen;
    localparam int NCH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       tx_run = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cw_level;
    logic [7:0] cw_oe;

    cw_beam_gen i_cw_beam_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_run(tx_run),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cw_level(cw_level), .cw_oe(cw_oe)
    );

    always #10 clk = ~clk;

    // Reference model state.
    int  reg_dly [NCH];
    int  reg_div;
    int  reg_mask;
    int  cap_dly [NCH];
    int  cap_div;
    int  cap_mask;
    bit  m_run;
    int  m_n;
    bit  started = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    int  cycles = 0;
    string tag = "R1";

    function automatic bit exp_level(int c);
        int m;
        if (!m_run || cap_mask[c]) return 0;
        if (m_n < cap_dly[c]) return 0;
        m = m_n - cap_dly[c];
        return ((m / (cap_div + 1)) % 2) == 1;
    endfunction

    // Model update at each rising edge, from the inputs held since the falling edge.
    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (!rst_n) begin
            foreach (reg_dly[c]) reg_dly[c] = 0;
            reg_div = 0; reg_mask = 0; m_run = 0; m_n = 0;
        end else begin
            if (enable && tx_run) begin
                if (!m_run) begin
                    foreach (cap_dly[c]) cap_dly[c] = reg_dly[c];
                    cap_div = reg_div; cap_mask = reg_mask;
                    m_run = 1; m_n = 0;
                end else m_n++;
            end else m_run = 0;
            if (cfg_we) begin
                if (cfg_addr < 8) reg_dly[cfg_addr] = cfg_wdata;
                else if (cfg_addr == 8) reg_div = cfg_wdata;
                else if (cfg_addr == 9) reg_mask = cfg_wdata;
            end
        end
    end

    // Compare outputs at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            logic [7:0] eo, el;
            for (int c = 0; c < NCH; c++) begin
                eo[c] = m_run && !cap_mask[c];
                el[c] = exp_level(c);
            end
            n_checks++;
            if (cw_oe !== eo || cw_level !== el) begin
                n_fail++;
                $display("FAIL %s t=%0t oe=%b lvl=%b expected oe=%b lvl=%b",
                         tag, $time, cw_oe, cw_level, eo, el);
            end
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: an overrun counts as a failed check.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        tag = "R1";
        tick(4);
        rst_n = 1; enable = 1;
        tick(3);
        // R1: run straight after reset with reset settings (div 0, delay 0)
        tx_run = 1; tick(12); tx_run = 0; tick(2);

        // R7: program delays, divider, mask; ignored addresses 10..15
        tag = "R7";
        wr(0, 0); wr(1, 1); wr(2, 2); wr(3, 3);
        wr(4, 5); wr(5, 8); wr(6, 13); wr(7, 21);
        wr(8, 2); wr(9, 0);
        for (int a = 10; a < 16; a++) wr(a, 8'hff);
        tick(2);

        // R2 / R3: steered run with divider 2
        tag = "R3";
        tx_run = 1; tick(80);

        // R4: stop, outputs go high impedance
        tag = "R4";
        tx_run = 0; tick(6);

        // R9: restart reproduces the same phases
        tag = "R9";
        tx_run = 1; tick(80);

        // R8: writes during a run are held until next start
        tag = "R8";
        wr(8, 0); wr(0, 7); wr(9, 8'h0f); wr(3, 0);
        tick(40);
        tx_run = 0; tick(3);

        // R5 / R2: new mask and divider 0 take effect
        tag = "R5";
        tx_run = 1; tick(50);
        tx_run = 0; tick(2);

        // R6: enable low during tx_run idles the block, then restarts
        tag = "R6";
        wr(9, 8'h81);
        tx_run = 1; tick(20);
        enable = 0; tick(8);
        enable = 1; tick(30);
        tx_run = 0; tick(2);

        // R8: write coincides with the start edge
        tag = "R8";
        cfg_we = 1; cfg_addr = 4'd8; cfg_wdata = 8'd3; tx_run = 1;
        @(negedge clk); cfg_we = 0;
        tick(40);
        tx_run = 0; tick(2);
        tx_run = 1; tick(40);
        tx_run = 0; tick(2);

        // R3: boundary delays 255 and 254 with a long divider
        tag = "R3";
        wr(9, 0); wr(8, 9); wr(7, 255); wr(6, 254); wr(0, 0);
        tx_run = 1; tick(320);
        tx_run = 0; tick(2);

        // R2: largest divider
        tag = "R2";
        wr(8, 255); wr(7, 1);
        tx_run = 1; tick(1100);

        // R1: reset in the middle of a run
        tag = "R1";
        rst_n = 0; tick(3);
        rst_n = 1; tick(20);
        tx_run = 0; tick(2);

        finish_run();
    end
endmodule